// File: doc/BRIEF.md
# SMBus Configuration Target

This block is a serial target that connects a two-wire SMBus/I2C-style bus to a small bank of configuration bytes. The bank itself sits outside the block. A fast system clock samples both bus lines and passes them through synchronizers. The block finds start, repeated-start and stop conditions on the synchronized lines. It answers only its fixed 7-bit address, 0x69. It pulls SDA low through an open-drain enable.

The command byte chooses between two kinds of transfer. In the indexed kind, one byte is accessed at a chosen offset. In the block kind, the access always begins at offset zero. A block write carries a byte count before its data. A block read sends a byte count before its data. Toward the bank the block presents an offset, write data with a one-cycle write strobe, and a read strobe. The read strobe samples combinational read data in the same cycle.

Top module: `smb_cfg_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0x69 (0xD2 for write, 0xD3 for read). For any other address it leaves SDA released for the address acknowledge slot and for every following bus clock, until the next START or STOP.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A START in any state restarts address reception. A STOP ends the transfer with SDA released.
- R3: A command byte with bit 7 = 1 selects indexed mode, with offset = bits 6:0. In a write, the next data byte is acknowledged and produces exactly one write strobe at that offset.
- R4: An indexed read (0xD2, command, repeated START, 0xD3) returns the byte at the commanded offset, most significant bit first, with one read strobe.
- R5: Command 0x00 selects block mode. The byte-count byte is acknowledged. Data bytes that follow are written to offsets 0, 1, 2 and upward, each acknowledged. A STOP after any complete byte leaves the later offsets untouched.
- R6: A block read first returns the byte count NREG (7). It then returns data from offset 0 upward while the host acknowledges. After the host NACK the block releases SDA.
- R7: Data written at offsets NREG and above is acknowledged but produces no write strobe. Bytes read from such offsets read as 0xFF and produce no read strobe.
- R8: The SDA enable changes only while the synchronized SCL is low, apart from the release forced by START or STOP.
- R9: The write and read strobes are never high together. Each strobe carries an offset below NREG.
- R10: After reset, SDA is released and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_off | output | 7 | Bank offset for the current access |
| reg_wdata | output | 8 | Byte to write into the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe; reg_rdata sampled in this cycle |
| reg_rdata | input | 8 | Combinational read data for reg_off |

## Verification
The assertions check, on every cycle, the properties that do not depend on the content of a transfer:
- The SDA enable changes only in the low phase of SCL.
- A START moves the state machine to address reception, and a STOP leaves SDA released.
- The idle state never drives the line.
- The two bank strobes are exclusive and stay in range.

Whether a transfer carries the right content shows only in the bench scenarios. These cover:
- byte values shifted MSB first;
- the byte count that leads a block read;
- offset auto-increment;
- the discard and pad rules past the last offset;
- the silence that follows a foreign address.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_COUNT,
    S_WDATA,
    S_TXCNT,
    S_TXDAT
  } smbt_state_e;

  // Upper seven bits of an address byte against the target's own address.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] own);
    return (b[7:1] == own);
  endfunction

  // Bit 7 set: single indexed byte; clear: block transfer.
  function automatic logic cmd_indexed(input logic [7:0] c);
    return c[7];
  endfunction

  // Indexed transfers start at bits 6:0, block transfers at zero.
  function automatic logic [6:0] cmd_first_off(input logic [7:0] c);
    return c[7] ? c[6:0] : 7'd0;
  endfunction

  function automatic logic off_valid(input logic [6:0] o, input int n);
    return (int'({1'b0, o}) < n);
  endfunction

  // Bytes beyond the implemented range read as all ones.
  function automatic logic [7:0] pad_read(input logic valid, input logic [7:0] d);
    return valid ? d : 8'hFF;
  endfunction

endpackage

// File: rtl/smbt_linesync.sv
module smbt_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int W = 2 * STAGES;

  logic [W-1:0] pipe;
  logic [1:0]   prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
      prev <= 2'b11;
    end else begin
      pipe <= {pipe[W-3:0], scl_i, sda_i};
      prev <= pipe[W-1:W-2];
    end
  end

  assign scl_s    = pipe[W-1];
  assign sda_s    = pipe[W-2];
  assign scl_rise = scl_s & ~prev[1];
  assign scl_fall = ~scl_s & prev[1];
  assign start_ev = scl_s & prev[1] & prev[0] & ~sda_s;
  assign stop_ev  = scl_s & prev[1] & ~prev[0] & sda_s;

endmodule

// File: rtl/smbt_proto.sv
module smbt_proto
  import smbt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h69,
  parameter int         NREG        = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_ev,
  input  logic        stop_ev,
  output logic        sda_oe,
  output logic [6:0]  reg_off,
  output logic [7:0]  reg_wdata,
  output logic        reg_we,
  output logic        reg_re,
  input  logic [7:0]  reg_rdata,
  output smbt_state_e state_o
);
  localparam logic [7:0] COUNT_BYTE = 8'(NREG);

  smbt_state_e st;
  logic [3:0]  bitcnt;
  logic        in_ack;
  logic        host_nack;
  logic        blk;
  logic        oe;
  logic [7:0]  sh;
  logic [6:0]  off;

  logic       is_tx, byte_full, rx_ack, load_tx, cur_valid;
  logic [7:0] rd_byte;

  assign is_tx     = (st == S_TXCNT) || (st == S_TXDAT);
  assign byte_full = (bitcnt == 4'd8);
  assign cur_valid = off_valid(off, NREG);
  assign rd_byte   = pad_read(cur_valid, reg_rdata);
  assign rx_ack    = (st == S_ADDR) ? addr_hit(sh, TARGET_ADDR)
                   : ((st == S_CMD) || (st == S_COUNT) || (st == S_WDATA));

  // Second falling edge of an acknowledge slot where the next byte is fetched.
  assign load_tx = scl_fall && in_ack &&
                   (((st == S_ADDR) && sh[0] && !blk) || (is_tx && !host_nack));

  assign reg_re    = load_tx && cur_valid;
  assign reg_we    = scl_fall && byte_full && !in_ack && (st == S_WDATA) && cur_valid;
  assign reg_off   = off;
  assign reg_wdata = sh;
  assign sda_oe    = oe;
  assign state_o   = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      in_ack    <= 1'b0;
      host_nack <= 1'b0;
      blk       <= 1'b0;
      oe        <= 1'b0;
      sh        <= '0;
      off       <= '0;
    end else if (start_ev) begin
      st        <= S_ADDR;
      bitcnt    <= '0;
      in_ack    <= 1'b0;
      host_nack <= 1'b0;
      oe        <= 1'b0;
    end else if (stop_ev) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      oe     <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (!byte_full) begin
          bitcnt <= bitcnt + 4'd1;
          if (!is_tx) sh <= {sh[6:0], sda_s};
        end else if (in_ack && is_tx) begin
          host_nack <= sda_s;
        end
      end else if (scl_fall) begin
        if (byte_full && !in_ack) begin
          in_ack <= 1'b1;
          if (is_tx) begin
            oe <= 1'b0;
          end else begin
            oe <= rx_ack;
            unique case (st)
              S_ADDR:  if (!rx_ack) st <= S_IDLE;
              S_CMD: begin
                blk <= !cmd_indexed(sh);
                off <= cmd_first_off(sh);
              end
              S_WDATA: if (cur_valid) off <= off + 7'd1;
              default: ;
            endcase
          end
        end else if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          unique case (st)
            S_ADDR: begin
              if (!sh[0]) begin
                st <= S_CMD;
                oe <= 1'b0;
              end else if (blk) begin
                st <= S_TXCNT;
                sh <= COUNT_BYTE;
                oe <= ~COUNT_BYTE[7];
              end else begin
                st <= S_TXDAT;
                sh <= rd_byte;
                oe <= ~rd_byte[7];
                if (cur_valid) off <= off + 7'd1;
              end
            end
            S_CMD: begin
              st <= blk ? S_COUNT : S_WDATA;
              oe <= 1'b0;
            end
            S_COUNT: begin
              st <= S_WDATA;
              oe <= 1'b0;
            end
            S_WDATA: oe <= 1'b0;
            S_TXCNT, S_TXDAT: begin
              if (host_nack) begin
                st <= S_IDLE;
                oe <= 1'b0;
              end else begin
                st <= S_TXDAT;
                sh <= rd_byte;
                oe <= ~rd_byte[7];
                if (cur_valid) off <= off + 7'd1;
              end
            end
            default: oe <= 1'b0;
          endcase
        end else if (is_tx && (bitcnt != 4'd0)) begin
          sh <= {sh[6:0], 1'b0};
          oe <= ~sh[6];
        end
      end
    end
  end

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smbt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h69,
  parameter int         NREG        = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [6:0] reg_off,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);
  // Named internal events, visible to the bound checker.
  logic        scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  smbt_state_e fsm_state;

  smbt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smbt_proto #(.TARGET_ADDR(TARGET_ADDR), .NREG(NREG)) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_oe    (sda_oe),
    .reg_off   (reg_off),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .state_o   (fsm_state)
  );

endmodule

// File: rtl/smbt_chk.sv
module smbt_chk
  import smbt_pkg::*;
#(
  parameter int NREG = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_s,
  input logic        start_ev,
  input logic        stop_ev,
  input logic        reg_we,
  input logic        reg_re,
  input logic [6:0]  reg_off,
  input smbt_state_e st
);

  assert_oe_in_low_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_s));

  assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == S_ADDR));

  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> ((st == S_IDLE) && !sda_oe));

  assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  assert_we_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (int'({1'b0, reg_off}) < NREG));

  assert_re_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> (int'({1'b0, reg_off}) < NREG));

endmodule

bind smb_cfg_target smbt_chk #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_s    (scl_s),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .reg_we   (reg_we),
  .reg_re   (reg_re),
  .reg_off  (reg_off),
  .st       (fsm_state)
);

// File: tb/sim_smb_cfg_target.sv
module sim_smb_cfg_target;
  localparam int H  = 10;
  localparam int NR = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sda_oe;
  logic [6:0] reg_off;
  logic [7:0] reg_wdata;
  logic       reg_we, reg_re;
  logic [7:0] reg_rdata;
  logic       sda_line;

  logic [7:0] bank [NR];
  logic [7:0] expv [NR];
  int vectors = 0, misses = 0;
  int mon_vec = 0, mon_miss = 0;
  int we_cnt = 0, re_cnt = 0, oe_cycles = 0;
  bit prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  smb_cfg_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  always_comb reg_rdata = (reg_off < 7'(NR)) ? bank[reg_off[2:0]] : 8'h00;

  // Bank model and per-clock checks, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) bank[i] = 8'h30 + 8'(i);
      prev_oe = 1'b0;
    end else begin
      mon_vec++;
      if (reg_we && reg_off < 7'(NR)) bank[reg_off[2:0]] = reg_wdata;
      if (reg_we) we_cnt++;
      if (reg_re) re_cnt++;
      if (sda_oe) oe_cycles++;
      if (sda_oe != prev_oe && scl_drv) begin
        mon_miss++;
        $display("FAIL R8: sda_oe changed to %0d with SCL high, expected change only with SCL low", sda_oe);
      end
      if (reg_we && reg_re) begin
        mon_miss++;
        $display("FAIL R9: we=%0d re=%0d, expected not both", reg_we, reg_re);
      end
      if ((reg_we || reg_re) && reg_off >= 7'(NR)) begin
        mon_miss++;
        $display("FAIL R9: strobe at offset %0h, expected below %0h", reg_off, NR);
      end
      prev_oe = sda_oe;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; step(H); scl_drv = 1'b1; step(H);
    sda_drv = 1'b0; step(H); scl_drv = 1'b0; step(H);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; step(H); scl_drv = 1'b1; step(H); sda_drv = 1'b1; step(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; step(H); scl_drv = 1'b1; step(H); scl_drv = 1'b0; step(2);
    end
    sda_drv = 1'b1; step(H); scl_drv = 1'b1; step(H/2);
    acked = (sda_line == 1'b0);
    step(H/2); scl_drv = 1'b0; step(2);
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      step(H); scl_drv = 1'b1; step(H/2); b[i] = sda_line; step(H/2); scl_drv = 1'b0; step(2);
    end
    sda_drv = nack; step(H); scl_drv = 1'b1; step(H); scl_drv = 1'b0; step(2);
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] v);
    bit a;
    bus_start;
    put_byte(8'hD2, a);            chk("R1 write address ack", a, 1);
    put_byte({1'b1, off}, a);      chk("R3 indexed command ack", a, 1);
    put_byte(v, a);                chk("R3 indexed data ack", a, 1);
    bus_stop;
    if (off < 7'(NR)) expv[off[2:0]] = v;
  endtask

  task automatic byte_read(input logic [6:0] off, output logic [7:0] v);
    bit a;
    bus_start;
    put_byte(8'hD2, a);            chk("R1 write address ack", a, 1);
    put_byte({1'b1, off}, a);      chk("R4 command ack", a, 1);
    bus_start;
    put_byte(8'hD3, a);            chk("R1 read address ack", a, 1);
    get_byte(1'b1, v);
    bus_stop;
  endtask

  task automatic block_write(input int cnt, input int nsend, input logic [7:0] base);
    bit a;
    bus_start;
    put_byte(8'hD2, a);            chk("R5 address ack", a, 1);
    put_byte(8'h00, a);            chk("R5 block command ack", a, 1);
    put_byte(8'(cnt), a);          chk("R5 count ack", a, 1);
    for (int i = 0; i < nsend; i++) begin
      put_byte(base + 8'(i), a);
      chk(i < NR ? "R5 data ack" : "R7 data ack past end", a, 1);
      if (i < NR) expv[i] = base + 8'(i);
    end
    bus_stop;
  endtask

  task automatic block_read(input int ndata);
    bit a;
    logic [7:0] v;
    bus_start;
    put_byte(8'hD2, a);            chk("R6 address ack", a, 1);
    put_byte(8'h00, a);            chk("R6 block command ack", a, 1);
    bus_start;
    put_byte(8'hD3, a);            chk("R6 read address ack", a, 1);
    get_byte(1'b0, v);             chk("R6 leading byte count", v, NR);
    for (int i = 0; i < ndata; i++) begin
      get_byte(i == ndata - 1, v);
      if (i < NR) chk("R6 block data", v, expv[i]);
      else        chk("R7 pad past end", v, 8'hFF);
    end
    bus_stop;
    chk("R6 released after NACK", sda_oe, 0);
  endtask

  initial begin
    logic [7:0] v;
    bit a;
    int w0, r0, o0;
    for (int i = 0; i < NR; i++) expv[i] = 8'h30 + 8'(i);
    step(3);
    chk("R10 sda released in reset", sda_oe, 0);
    chk("R10 no write strobe", reg_we, 0);
    chk("R10 no read strobe", reg_re, 0);
    rst_n = 1'b1;
    step(5);
    chk("R10 sda released after reset", sda_oe, 0);

    // Indexed write then read back.
    w0 = we_cnt;
    byte_write(7'd3, 8'hA5);
    chk("R3 one write strobe", we_cnt - w0, 1);
    r0 = re_cnt;
    byte_read(7'd3, v);
    chk("R4 indexed read value", v, 8'hA5);
    chk("R4 one read strobe", re_cnt - r0, 1);
    byte_read(7'd5, v);
    chk("R4 untouched neighbour", v, expv[5]);

    // Full block write, then block read.
    w0 = we_cnt;
    block_write(NR, NR, 8'h10);
    chk("R5 seven write strobes", we_cnt - w0, NR);
    block_read(NR);

    // Block write past the end: acknowledged, discarded.
    w0 = we_cnt;
    block_write(9, 9, 8'hC0);
    chk("R7 writes past end discarded", we_cnt - w0, NR);
    block_read(NR + 1);
    r0 = re_cnt;
    byte_read(7'h7F, v);
    chk("R7 out-of-range indexed read", v, 8'hFF);
    chk("R7 no read strobe out of range", re_cnt - r0, 0);

    // Partial block write stopped after two bytes.
    block_write(NR, 2, 8'h5A);
    block_read(NR);

    // Foreign address: no acknowledge and silence until STOP.
    w0 = we_cnt;
    o0 = oe_cycles;
    bus_start;
    put_byte(8'hA4, a);  chk("R1 foreign address not acked", a, 0);
    put_byte(8'h81, a);  chk("R1 ignored byte not acked", a, 0);
    put_byte(8'h00, a);  chk("R1 ignored byte not acked", a, 0);
    bus_stop;
    chk("R1 SDA never driven after mismatch", oe_cycles - o0, 0);
    chk("R1 no write after mismatch", we_cnt - w0, 0);

    // Repeated START in the middle of a write restarts address reception.
    bus_start;
    put_byte(8'hD2, a);  chk("R2 address ack", a, 1);
    put_byte(8'h81, a);  chk("R2 command ack", a, 1);
    bus_start;
    put_byte(8'hD3, a);  chk("R2 read address ack after restart", a, 1);
    get_byte(1'b1, v);   chk("R2 read after restart", v, expv[1]);
    bus_stop;
    chk("R2 released after STOP", sda_oe, 0);

    // Indexed write at the last offset, MSB-first pattern.
    byte_write(7'd6, 8'h81);
    byte_read(7'd6, v);
    chk("R4 MSB-first pattern", v, 8'h81);

    step(20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_vec, misses + mon_miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_vec + 1, misses + mon_miss + 1);
    $finish;
  end

endmodule